// File: doc/BRIEF.md
# String I/O Transfer Sequencer

This block carries out the string port-input and string port-output operations of a 16-bit segmented core. One accepted start moves one element, or a counted run of elements, between the I/O port held in DX and memory. An input operation reads the port and stores the element at ES:DI. An output operation fetches the element from SI and sends it to the port. Its source segment is either a supplied override segment or DS. Elements are bytes or words, and the index register steps up or down after each one, as the direction flag selects.

With a repeat prefix, CX counts the elements. The sequencer returns to its repeat check after every element and stops once CX reaches zero, including when CX is zero on entry. The block does not stall to model the bus cost. It keeps a running wait-cycle total that charges an entry cost, a one-time setup cost and a per-element access cost. The per-element cost depends on the element size, on the parity of the port address and on whether the core is the 16-bit-bus variant.

The memory and I/O sides each use a plain request/acknowledge handshake. A done pulse marks the cycle on which the final SI, DI and CX values are presented.

Top module: `strio_seq`

## Requirements
- R1: A start in the idle state with opcode bits [7:2] equal to 6'b011011 (opcodes 0x6C to 0x6F) begins an operation and raises busy. A start with any other opcode, or a start while busy, is ignored.
- R2: Opcode bit 0 selects the element size (0 byte, 1 word). Opcode bit 1 selects the direction. 0 is input: an I/O read of port DX followed by a memory write at ES:DI. 1 is output: a memory read at SI followed by an I/O write to port DX.
- R3: For output, the memory segment is ovr_seg when ovr_valid is high at start, and ds_in otherwise.
- R4: After each element, the index register steps by 1 for bytes or 2 for words. It decrements when dir_flag was set at start and increments otherwise. Input changes only DI and output changes only SI.
- R5: Without a repeat prefix, exactly one element is transferred and CX is returned unchanged.
- R6: With a repeat prefix, the repeat check ends the operation with no transfer when CX is zero. Otherwise one element is transferred and CX is decremented by one, and the check is repeated.
- R7: wait_cnt is set to 2 when an operation is accepted. The first time an element is about to be transferred, 7 more are added. Neither cost recurs on later elements.
- R8: Each element adds 4 when it is a byte. A word adds 4 when wide_bus is 1 and DX bit 0 is 0, and 8 otherwise. wait_cnt never decreases during an operation and holds its total until the next accepted start.
- R9: done is high for exactly one clock at the end of an operation. On that cycle si_out, di_out and cx_out carry the final values, and they hold until the next accepted start.
- R10: At most one of mem_req and io_req is high at a time, and each is held until its acknowledge. Byte elements travel in bits [7:0], and the upper bits written are zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (one cycle) |
| opcode | input | 8 | Instruction opcode, 0x6C to 0x6F accepted |
| rep_pfx | input | 1 | Repeat prefix present |
| dir_flag | input | 1 | Direction flag, 1 = decrement index |
| ovr_valid | input | 1 | Segment override present |
| ovr_seg | input | 16 | Override segment value |
| wide_bus | input | 1 | 1 = 16-bit-bus core variant |
| dx_in | input | 16 | Port address |
| ds_in | input | 16 | Data segment |
| es_in | input | 16 | Extra segment |
| si_in | input | 16 | Source index at start |
| di_in | input | 16 | Destination index at start |
| cx_in | input | 16 | Count at start |
| si_out | output | 16 | Current/final source index |
| di_out | output | 16 | Current/final destination index |
| cx_out | output | 16 | Current/final count |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| wait_cnt | output | 32 | Wait cycles charged by the current or last operation |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Memory write (1) or read (0) |
| mem_word | output | 1 | Word access |
| mem_seg | output | 16 | Memory segment |
| mem_off | output | 16 | Memory offset |
| mem_wdata | output | 16 | Memory write data |
| mem_rdata | input | 16 | Memory read data, valid with mem_ack |
| mem_ack | input | 1 | Memory acknowledge |
| io_req | output | 1 | I/O request |
| io_we | output | 1 | I/O write (1) or read (0) |
| io_word | output | 1 | Word I/O access |
| io_port | output | 16 | I/O port address |
| io_wdata | output | 16 | I/O write data |
| io_rdata | input | 16 | I/O read data, valid with io_ack |
| io_ack | input | 1 | I/O acknowledge |

## Verification
The hardest situation to reach is the repeat check that ends on entry. Only a repeat-prefixed start with CX already zero reaches it, and there the total must stay at the entry cost with no request of any kind. The bench drives exactly that start and counts I/O reads and memory writes across it. It separates the three word-access cost cases by running the same word output with an odd port, with an even port on the narrow variant, and with an even port on the wide variant. The decrementing word repeat run confirms that the setup cost is charged only once.

// File: rtl/strio_pkg.sv
package strio_pkg;

    localparam int REG_W          = 16;
    localparam int CNT_W          = 32;
    localparam int ENTRY_COST     = 2;
    localparam int SETUP_COST     = 7;
    localparam int BYTE_COST      = 4;
    localparam int WORD_FAST_COST = 4;
    localparam int WORD_SLOW_COST = 8;
    localparam logic [5:0] OPC_FAMILY = 6'b011011;

    typedef enum logic [2:0] {
        S_IDLE,
        S_CHECK,
        S_FETCH,
        S_STORE,
        S_DONE
    } seq_state_e;

    typedef struct packed {
        logic is_out;
        logic is_word;
        logic rep;
        logic dir_dn;
        logic wide_bus;
        logic port_odd;
    } op_cfg_t;

    function automatic logic opc_accepted(input logic [7:0] opc);
        return opc[7:2] == OPC_FAMILY;
    endfunction

endpackage

// File: rtl/strio_cost.sv
module strio_cost #(
    parameter int CW        = 32,
    parameter int SETUP     = 7,
    parameter int BYTE_C    = 4,
    parameter int WORD_FAST = 4,
    parameter int WORD_SLOW = 8
) (
    input  logic          first,
    input  logic          is_word,
    input  logic          port_odd,
    input  logic          wide_bus,
    output logic [CW-1:0] charge
);
    logic [CW-1:0] elem_c;
    logic [CW-1:0] setup_c;

    always_comb begin
        if (!is_word)
            elem_c = CW'(BYTE_C);
        else if (wide_bus && !port_odd)
            elem_c = CW'(WORD_FAST);
        else
            elem_c = CW'(WORD_SLOW);
        setup_c = first ? CW'(SETUP) : '0;
        charge  = elem_c + setup_c;
    end
endmodule

// File: rtl/strio_step.sv
module strio_step #(
    parameter int W = 16
) (
    input  logic [W-1:0] idx,
    input  logic         is_word,
    input  logic         dir_dn,
    output logic [W-1:0] nxt
);
    logic [W-1:0] amt;

    assign amt = is_word ? W'(2) : W'(1);
    assign nxt = dir_dn ? (idx - amt) : (idx + amt);
endmodule

// File: rtl/strio_seq.sv
module strio_seq
    import strio_pkg::*;
#(
    parameter int REG_W = strio_pkg::REG_W,
    parameter int CNT_W = strio_pkg::CNT_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic [7:0]       opcode,
    input  logic             rep_pfx,
    input  logic             dir_flag,
    input  logic             ovr_valid,
    input  logic [REG_W-1:0] ovr_seg,
    input  logic             wide_bus,
    input  logic [REG_W-1:0] dx_in,
    input  logic [REG_W-1:0] ds_in,
    input  logic [REG_W-1:0] es_in,
    input  logic [REG_W-1:0] si_in,
    input  logic [REG_W-1:0] di_in,
    input  logic [REG_W-1:0] cx_in,
    output logic [REG_W-1:0] si_out,
    output logic [REG_W-1:0] di_out,
    output logic [REG_W-1:0] cx_out,
    output logic             busy,
    output logic             done,
    output logic [CNT_W-1:0] wait_cnt,
    output logic             mem_req,
    output logic             mem_we,
    output logic             mem_word,
    output logic [REG_W-1:0] mem_seg,
    output logic [REG_W-1:0] mem_off,
    output logic [REG_W-1:0] mem_wdata,
    input  logic [REG_W-1:0] mem_rdata,
    input  logic             mem_ack,
    output logic             io_req,
    output logic             io_we,
    output logic             io_word,
    output logic [REG_W-1:0] io_port,
    output logic [REG_W-1:0] io_wdata,
    input  logic [REG_W-1:0] io_rdata,
    input  logic             io_ack
);
    localparam int HI_W = REG_W - 8;

    seq_state_e       st;
    op_cfg_t          op;
    logic [REG_W-1:0] si_r, di_r, cx_r, dx_r, seg_r, data_r;
    logic [CNT_W-1:0] cnt_r;
    logic             first_r;

    logic [CNT_W-1:0] charge;
    logic [REG_W-1:0] idx_cur, idx_nxt;
    logic [REG_W-1:0] fetch_data;
    logic             fetch_ack, store_ack;
    logic             take_start, rep_exit;

    strio_cost #(
        .CW       (CNT_W),
        .SETUP    (SETUP_COST),
        .BYTE_C   (BYTE_COST),
        .WORD_FAST(WORD_FAST_COST),
        .WORD_SLOW(WORD_SLOW_COST)
    ) cost_i (
        .first   (first_r),
        .is_word (op.is_word),
        .port_odd(op.port_odd),
        .wide_bus(op.wide_bus),
        .charge  (charge)
    );

    strio_step #(.W(REG_W)) step_i (
        .idx    (idx_cur),
        .is_word(op.is_word),
        .dir_dn (op.dir_dn),
        .nxt    (idx_nxt)
    );

    always_comb begin
        idx_cur    = op.is_out ? si_r : di_r;
        fetch_ack  = op.is_out ? mem_ack : io_ack;
        store_ack  = op.is_out ? io_ack : mem_ack;
        fetch_data = op.is_out ? mem_rdata : io_rdata;
        take_start = (st == S_IDLE) && start && opc_accepted(opcode);
        rep_exit   = op.rep && (cx_r == '0);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st      <= S_IDLE;
            op      <= '0;
            si_r    <= '0;
            di_r    <= '0;
            cx_r    <= '0;
            dx_r    <= '0;
            seg_r   <= '0;
            data_r  <= '0;
            cnt_r   <= '0;
            first_r <= 1'b0;
        end else begin
            unique case (st)
                S_IDLE: begin
                    if (take_start) begin
                        op.is_out   <= opcode[1];
                        op.is_word  <= opcode[0];
                        op.rep      <= rep_pfx;
                        op.dir_dn   <= dir_flag;
                        op.wide_bus <= wide_bus;
                        op.port_odd <= dx_in[0];
                        dx_r    <= dx_in;
                        seg_r   <= opcode[1] ? (ovr_valid ? ovr_seg : ds_in) : es_in;
                        si_r    <= si_in;
                        di_r    <= di_in;
                        cx_r    <= cx_in;
                        cnt_r   <= CNT_W'(ENTRY_COST);
                        first_r <= 1'b1;
                        st      <= S_CHECK;
                    end
                end
                S_CHECK: begin
                    if (rep_exit) begin
                        st <= S_DONE;
                    end else begin
                        cnt_r   <= cnt_r + charge;
                        first_r <= 1'b0;
                        if (op.rep) cx_r <= cx_r - REG_W'(1);
                        st <= S_FETCH;
                    end
                end
                S_FETCH: begin
                    if (fetch_ack) begin
                        data_r <= op.is_word ? fetch_data
                                             : {{HI_W{1'b0}}, fetch_data[7:0]};
                        st <= S_STORE;
                    end
                end
                S_STORE: begin
                    if (store_ack) begin
                        if (op.is_out) si_r <= idx_nxt;
                        else           di_r <= idx_nxt;
                        st <= op.rep ? S_CHECK : S_DONE;
                    end
                end
                S_DONE:  st <= S_IDLE;
                default: st <= S_IDLE;
            endcase
        end
    end

    always_comb begin
        busy      = (st != S_IDLE);
        done      = (st == S_DONE);
        si_out    = si_r;
        di_out    = di_r;
        cx_out    = cx_r;
        wait_cnt  = cnt_r;
        mem_req   = ((st == S_FETCH) && op.is_out) || ((st == S_STORE) && !op.is_out);
        mem_we    = (st == S_STORE);
        mem_word  = op.is_word;
        mem_seg   = seg_r;
        mem_off   = idx_cur;
        mem_wdata = data_r;
        io_req    = ((st == S_FETCH) && !op.is_out) || ((st == S_STORE) && op.is_out);
        io_we     = (st == S_STORE);
        io_word   = op.is_word;
        io_port   = dx_r;
        io_wdata  = data_r;
    end
endmodule

// File: rtl/strio_seq_chk.sv
module strio_seq_chk
    import strio_pkg::*;
#(
    parameter int REG_W = strio_pkg::REG_W,
    parameter int CNT_W = strio_pkg::CNT_W
) (
    input logic             clk,
    input logic             rst,
    input logic             start,
    input logic [7:0]       opcode,
    input logic             busy,
    input logic             done,
    input logic [CNT_W-1:0] wait_cnt,
    input logic [REG_W-1:0] cx_out,
    input logic             mem_req,
    input logic             io_req
);
    // R10
    one_req_chk: assert property (@(posedge clk) disable iff (rst)
        !(mem_req && io_req));

    // R9
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    cnt_mono_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (wait_cnt >= $past(wait_cnt)));

    // R6
    cx_mono_chk: assert property (@(posedge clk) disable iff (rst)
        busy |=> (cx_out <= $past(cx_out)));

    // R7
    entry_cost_chk: assert property (@(posedge clk) disable iff (rst)
        (start && !busy && (opcode[7:2] == OPC_FAMILY)) |=> (wait_cnt == CNT_W'(ENTRY_COST)));

    // R1
    req_busy_chk: assert property (@(posedge clk) disable iff (rst)
        (mem_req || io_req) |-> busy);
endmodule

bind strio_seq strio_seq_chk #(.REG_W(REG_W), .CNT_W(CNT_W)) chk_i (
    .clk     (clk),
    .rst     (rst),
    .start   (start),
    .opcode  (opcode),
    .busy    (busy),
    .done    (done),
    .wait_cnt(wait_cnt),
    .cx_out  (cx_out),
    .mem_req (mem_req),
    .io_req  (io_req)
);

// File: tb/strio_seq_tb.sv
module strio_seq_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [7:0]  opcode = '0;
    logic        rep_pfx = 1'b0, dir_flag = 1'b0, ovr_valid = 1'b0, wide_bus = 1'b1;
    logic [15:0] ovr_seg = '0, dx_in = '0, ds_in = 16'h0020, es_in = 16'h0010;
    logic [15:0] si_in = '0, di_in = '0, cx_in = '0;
    logic [15:0] si_out, di_out, cx_out;
    logic        busy, done;
    logic [31:0] wait_cnt;
    logic        mem_req, mem_we, mem_word, mem_ack = 1'b0;
    logic [15:0] mem_seg, mem_off, mem_wdata, mem_rdata = '0;
    logic        io_req, io_we, io_word, io_ack = 1'b0;
    logic [15:0] io_port, io_wdata, io_rdata = '0;

    logic [7:0]  bmem [0:1023];
    logic [15:0] io_log [0:63];
    int          io_wr_n = 0, io_rd_n = 0, mem_wr_n = 0;
    int          n_chk = 0, n_fail = 0;
    bit          finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    strio_seq dut_i (
        .clk(clk), .rst(rst), .start(start), .opcode(opcode), .rep_pfx(rep_pfx),
        .dir_flag(dir_flag), .ovr_valid(ovr_valid), .ovr_seg(ovr_seg), .wide_bus(wide_bus),
        .dx_in(dx_in), .ds_in(ds_in), .es_in(es_in), .si_in(si_in), .di_in(di_in),
        .cx_in(cx_in), .si_out(si_out), .di_out(di_out), .cx_out(cx_out), .busy(busy),
        .done(done), .wait_cnt(wait_cnt), .mem_req(mem_req), .mem_we(mem_we),
        .mem_word(mem_word), .mem_seg(mem_seg), .mem_off(mem_off), .mem_wdata(mem_wdata),
        .mem_rdata(mem_rdata), .mem_ack(mem_ack), .io_req(io_req), .io_we(io_we),
        .io_word(io_word), .io_port(io_port), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .io_ack(io_ack)
    );

    function automatic int baddr(input logic [15:0] seg, input logic [15:0] off);
        logic [19:0] lin;
        lin = {seg, 4'h0} + {4'h0, off};
        return int'(lin[9:0]);
    endfunction

    function automatic logic [7:0] init_byte(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    // Responders: acknowledge one negedge after a request is seen.
    always @(negedge clk) begin
        io_ack <= io_req && !io_ack;
        if (io_req && !io_ack && !io_we) begin
            io_rdata <= 16'hC300 + 16'(io_rd_n);
            io_rd_n  <= io_rd_n + 1;
        end
        mem_ack <= mem_req && !mem_ack;
        if (mem_req && !mem_ack && !mem_we)
            mem_rdata <= {bmem[baddr(mem_seg, mem_off + 16'd1)], bmem[baddr(mem_seg, mem_off)]};
    end

    always @(posedge clk) begin
        if (mem_req && mem_ack && mem_we) begin
            bmem[baddr(mem_seg, mem_off)] <= mem_wdata[7:0];
            if (mem_word) bmem[baddr(mem_seg, mem_off + 16'd1)] <= mem_wdata[15:8];
            mem_wr_n <= mem_wr_n + 1;
        end
        if (io_req && io_ack && io_we) begin
            io_log[io_wr_n[5:0]] <= io_wdata;
            io_wr_n <= io_wr_n + 1;
        end
    end

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic run_op(input logic [7:0] opc, input bit rep, input bit dn,
                          input bit ov, input logic [15:0] ovs, input bit wide,
                          input logic [15:0] dx, input logic [15:0] si,
                          input logic [15:0] di, input logic [15:0] cx);
        int t = 0;
        @(negedge clk);
        opcode = opc; rep_pfx = rep; dir_flag = dn; ovr_valid = ov; ovr_seg = ovs;
        wide_bus = wide; dx_in = dx; si_in = si; di_in = di; cx_in = cx; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        while (!done && t < 500) begin
            @(negedge clk);
            t++;
        end
        chk(done == 1'b1, "R9", "done seen", done, 1);
    endtask

    task automatic t_reset();
        chk(busy == 0 && done == 0, "R1", "idle after reset", {busy, done}, 0);
        chk(mem_req == 0 && io_req == 0, "R10", "no request after reset", {mem_req, io_req}, 0);
        chk(wait_cnt == 0, "R8", "count after reset", wait_cnt, 0);
    endtask

    task automatic t_in_byte_single();
        int n0 = io_rd_n;
        run_op(8'h6C, 0, 0, 0, 0, 1, 16'h0040, 16'h0077, 16'h0010, 16'd5);
        chk(di_out == 16'h0011, "R4", "byte input DI step", di_out, 16'h0011);
        chk(si_out == 16'h0077, "R4", "input leaves SI", si_out, 16'h0077);
        chk(cx_out == 16'd5, "R5", "no-repeat CX", cx_out, 5);
        chk(wait_cnt == 13, "R8", "byte single cost", wait_cnt, 13);
        chk(bmem[16'h110] == 8'(n0), "R2", "byte stored at ES:DI", bmem[16'h110], 8'(n0));
        chk(bmem[16'h111] == init_byte(16'h111), "R10", "neighbour byte kept",
            bmem[16'h111], init_byte(16'h111));
        chk(io_rd_n == n0 + 1, "R5", "one port read", io_rd_n, n0 + 1);
        @(negedge clk);
        chk(done == 0, "R9", "done one cycle", done, 0);
        chk(di_out == 16'h0011, "R9", "DI held after done", di_out, 16'h0011);
    endtask

    task automatic t_in_word_rep_down();
        int n0 = io_rd_n;
        run_op(8'h6D, 1, 1, 0, 0, 1, 16'h0042, 16'h0000, 16'h0020, 16'd3);
        chk(wait_cnt == 21, "R7", "setup charged once", wait_cnt, 21);
        chk(di_out == 16'h001A, "R4", "word DI down", di_out, 16'h001A);
        chk(cx_out == 16'd0, "R6", "CX run to zero", cx_out, 0);
        for (int k = 0; k < 3; k++) begin
            int a = 16'h120 - 2 * k;
            logic [15:0] got = {bmem[a + 1], bmem[a]};
            chk(got == 16'hC300 + 16'(n0 + k), "R2", "word stored", got, 16'hC300 + 16'(n0 + k));
        end
    endtask

    task automatic t_out_byte_rep_ovr();
        int k0 = io_wr_n;
        run_op(8'h6E, 1, 0, 1, 16'h0030, 1, 16'h0051, 16'h0040, 16'h0099, 16'd2);
        chk(wait_cnt == 17, "R8", "two bytes cost", wait_cnt, 17);
        chk(si_out == 16'h0042, "R4", "byte SI up", si_out, 16'h0042);
        chk(di_out == 16'h0099, "R4", "output leaves DI", di_out, 16'h0099);
        chk(io_log[k0] == {8'h00, init_byte(16'h340)}, "R3", "override segment byte 0",
            io_log[k0], {8'h00, init_byte(16'h340)});
        chk(io_log[k0 + 1] == {8'h00, init_byte(16'h341)}, "R10", "byte upper bits zero",
            io_log[k0 + 1], {8'h00, init_byte(16'h341)});
    endtask

    task automatic t_out_word_costs();
        int k0 = io_wr_n;
        run_op(8'h6F, 0, 1, 0, 0, 1, 16'h0033, 16'h0060, 16'h0000, 16'd9);
        chk(wait_cnt == 17, "R8", "word odd port cost", wait_cnt, 17);
        chk(si_out == 16'h005E, "R4", "word SI down", si_out, 16'h005E);
        chk(cx_out == 16'd9, "R5", "CX unchanged", cx_out, 9);
        chk(io_log[k0] == {init_byte(16'h261), init_byte(16'h260)}, "R3", "DS segment word",
            io_log[k0], {init_byte(16'h261), init_byte(16'h260)});
        run_op(8'h6F, 0, 0, 0, 0, 0, 16'h0034, 16'h0070, 16'h0000, 16'd1);
        chk(wait_cnt == 17, "R8", "word narrow even cost", wait_cnt, 17);
        chk(si_out == 16'h0072, "R4", "word SI up", si_out, 16'h0072);
        run_op(8'h6F, 0, 0, 0, 0, 1, 16'h0034, 16'h0070, 16'h0000, 16'd1);
        chk(wait_cnt == 13, "R8", "word wide even cost", wait_cnt, 13);
        chk(io_log[k0 + 2] == {init_byte(16'h271), init_byte(16'h270)}, "R2", "word output data",
            io_log[k0 + 2], {init_byte(16'h271), init_byte(16'h270)});
    endtask

    task automatic t_rep_zero();
        int r0 = io_rd_n;
        int w0 = mem_wr_n;
        run_op(8'h6C, 1, 0, 0, 0, 1, 16'h0040, 16'h0000, 16'h0030, 16'd0);
        chk(wait_cnt == 2, "R6", "zero count cost", wait_cnt, 2);
        chk(di_out == 16'h0030, "R6", "zero count DI", di_out, 16'h0030);
        chk(io_rd_n == r0 && mem_wr_n == w0, "R6", "no transfer", io_rd_n - r0 + mem_wr_n - w0, 0);
    endtask

    task automatic t_bad_opcode();
        bit seen = 0;
        @(negedge clk);
        opcode = 8'h6A; cx_in = 16'd4; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (busy || done) seen = 1;
            @(negedge clk);
        end
        chk(!seen, "R1", "foreign opcode ignored", seen, 0);
        chk(wait_cnt == 2 && cx_out == 16'd0, "R1", "state kept", wait_cnt, 2);
    endtask

    initial begin
        for (int i = 0; i < 1024; i++) bmem[i] = init_byte(i);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_in_byte_single();
        t_in_word_rep_down();
        t_out_byte_rep_ovr();
        t_out_word_costs();
        t_rep_zero();
        t_bad_opcode();
        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule